// File: doc/BRIEF.md
# Write-Once Flash Timing Clock Divider

This block turns the fast oscillator clock into the slow timing beat that flash program and erase sequencing counts against. Software programs one 8-bit control register over a simple register bus. The low seven bits hold the configuration: a prescaler select and a 6-bit divide value. They accept exactly one write after reset. After that write the register is locked until the next reset, and a read-only status bit shows that the lock has been taken.

The output is a single-cycle enable pulse in the oscillator clock domain, not a derived clock. The divide ratio is (divide value + 1), multiplied by 8 when the prescaler is selected, so the largest ratio is 512. Software must choose a setting that puts the pulse rate between 150 kHz and 200 kHz. A valid flag copies the status bit. Downstream command logic must not start a program or erase operation while that flag is low.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset, regRdata reads 0x00, dividerValid is 0 and tickPulse is 0.
- R2: A write (regSel=1 and regWr=1 at a rising edge) while the status bit is 0 stores regWdata[6:0] into bits 6..0 and sets bit 7. From the next cycle on, regRdata reads {1, regWdata[6:0]}.
- R3: Bit 7 cannot be written. Its value is set only by the locking write, whatever regWdata[7] carries.
- R4: Once bit 7 is 1, every further write is ignored until reset. The readback and the pulse cadence are unchanged.
- R5: A write strobe without regSel has no effect.
- R6: With bit 6 = 0, tickPulse fires once every (bits 5..0 + 1) cycles.
- R7: With bit 6 = 1, tickPulse fires once every 8 × (bits 5..0 + 1) cycles. The maximum is 512.
- R8: The counters restart on the locking write. The first pulse is high in the cycle after rising edge E0+R, where E0 is the locking edge and R is the ratio. Each pulse lasts one cycle when R > 1.
- R9: dividerValid always equals bit 7, and no pulse is produced while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register select |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data: {status, prescale select, divide value} |
| tickPulse | output | 1 | Single-cycle timing enable |
| dividerValid | output | 1 | High once the configuration is locked |

## Verification
The hardest case to reach from the ports is a second write that lands in the middle of an active pulse train. It must change neither the readback nor the cadence. Because the register locks, every configuration needs its own reset. The stimulus therefore resets the block, locks one configuration, and then, one cycle after the first pulse, fires a write with inverted data while it compares every cycle against a model of the pulse train. The configurations are directed extremes (ratio 1, 8, 64 and 512, plus bit 7 set in the write data) followed by seeded random settings.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;
  localparam int REG_W = 8;
  localparam int CFG_W = REG_W - 1;
  localparam int DIV_W = CFG_W - 1;

  typedef struct packed {
    logic             lockWrite;
    logic             armed;
    logic             prescaleEn;
    logic [DIV_W-1:0] divValue;
  } divCtlT;
endpackage

// File: rtl/flash_tick_ctrl.sv
module flash_tick_ctrl
  import flash_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output divCtlT           ctl
);
  logic [CFG_W-1:0] cfgReg;
  logic             loaded;
  logic             wrHit;

  // Only the first selected write after reset is taken.
  assign wrHit = regSel && regWr && !loaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      loaded <= 1'b0;
    end else if (wrHit) begin
      cfgReg <= regWdata[CFG_W-1:0];
      loaded <= 1'b1;
    end
  end

  assign regRdata       = {loaded, cfgReg};
  assign ctl.lockWrite  = wrHit;
  assign ctl.armed      = loaded;
  assign ctl.prescaleEn = cfgReg[CFG_W-1];
  assign ctl.divValue   = cfgReg[DIV_W-1:0];
endmodule

// File: rtl/flash_tick_dp.sv
module flash_tick_dp
  import flash_tick_pkg::*;
#(
  parameter int PRE_RATIO = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  divCtlT ctl,
  output logic   tickPulse
);
  localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

  logic             preTick;
  logic [DIV_W-1:0] divCnt;
  logic             divHit;

  generate
    if (PRE_RATIO > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (ctl.lockWrite) begin
          preCnt <= '0;
        end else if (ctl.armed) begin
          preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
        end
      end
      assign preTick = !ctl.prescaleEn || (preCnt == PRE_LAST);
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  assign divHit = (divCnt == ctl.divValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      tickPulse <= 1'b0;
    end else if (ctl.lockWrite) begin
      divCnt    <= '0;
      tickPulse <= 1'b0;
    end else begin
      tickPulse <= ctl.armed && preTick && divHit;
      if (ctl.armed && preTick) begin
        divCnt <= divHit ? '0 : divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
  import flash_tick_pkg::*;
#(
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             tickPulse,
  output logic             dividerValid
);
  divCtlT ctl;

  flash_tick_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .ctl      (ctl)
  );

  flash_tick_dp #(.PRE_RATIO(PRE_RATIO)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .tickPulse (tickPulse)
  );

  assign dividerValid = ctl.armed;
endmodule

// File: rtl/flash_tick_checker.sv
module flash_tick_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       tickPulse,
  input logic       dividerValid
);
  assert_valid_is_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    dividerValid == regRdata[7]);

  assert_no_pulse_unloaded_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dividerValid |-> !tickPulse);

  assert_lock_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!dividerValid && regSel && regWr) |=>
      (dividerValid && regRdata[6:0] == $past(regWdata[6:0])));

  assert_locked_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    dividerValid |=> (dividerValid && $stable(regRdata)));

  assert_unselected_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dividerValid && !(regSel && regWr)) |=> !dividerValid);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tickPulse && regRdata[6:0] != 7'd0) |=> !tickPulse);
endmodule

bind flash_tick_divider flash_tick_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .regSel       (regSel),
  .regWr        (regWr),
  .regWdata     (regWdata),
  .regRdata     (regRdata),
  .tickPulse    (tickPulse),
  .dividerValid (dividerValid)
);

// File: tb/flash_tick_divider_bench.sv
module flash_tick_divider_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       tickPulse;
  logic       dividerValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  flash_tick_divider u_flash_tick_divider (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata),
    .tickPulse(tickPulse), .dividerValid(dividerValid)
  );

  always #5 clk = ~clk;

  function automatic int ratioOf(input logic [7:0] cfg);
    return (cfg[6] ? 8 : 1) * (int'(cfg[5:0]) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regSel = 1'b0; regWr = 1'b0; regWdata = 8'h00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Locks cfg, then walks 3*R cycles against the model, with a second write injected.
  task automatic runConfig(input logic [7:0] cfg);
    int r;
    int badCycle;
    int firstPulse;
    logic [7:0] expRd;
    r = ratioOf(cfg);
    expRd = {1'b1, cfg[6:0]};
    doReset();
    check(regRdata == 8'h00 && !dividerValid && !tickPulse, "R1 reset state",
          {dividerValid, tickPulse, regRdata}, 0);
    // stray strobe without select, then idle cycles
    regWr = 1'b1; regWdata = cfg;
    @(negedge clk);
    regWr = 1'b0;
    repeat (5) @(negedge clk);
    check(regRdata == 8'h00 && !dividerValid && !tickPulse, "R5/R9 unselected write, no pulse",
          {dividerValid, tickPulse, regRdata}, 0);
    // locking write at edge E0
    regSel = 1'b1; regWr = 1'b1; regWdata = cfg;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
    check(regRdata == expRd && dividerValid, "R2/R3 readback after lock", regRdata, expRd);
    badCycle = -1;
    firstPulse = -1;
    for (int k = 1; k <= 3 * r + 2; k++) begin
      if (k == r + 1) begin
        regSel = 1'b1; regWr = 1'b1; regWdata = ~cfg;
      end
      @(negedge clk);
      regSel = 1'b0; regWr = 1'b0;
      if (tickPulse && firstPulse < 0) firstPulse = k;
      if (tickPulse != ((k % r) == 0) && badCycle < 0) badCycle = k;
    end
    check(firstPulse == r, "R8 first pulse position", firstPulse, r);
    if (cfg[6])
      check(badCycle < 0, "R7 prescaled cadence, first bad cycle", badCycle, -1);
    else
      check(badCycle < 0, "R6 direct cadence, first bad cycle", badCycle, -1);
    check(regRdata == expRd && dividerValid, "R4 later write ignored", regRdata, expRd);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'h5eed_0042));
    runConfig(8'h00);   // ratio 1
    runConfig(8'h40);   // ratio 8
    runConfig(8'h3F);   // ratio 64
    runConfig(8'h7F);   // ratio 512, maximum
    runConfig(8'h85);   // bit 7 in write data ignored, ratio 6
    for (int i = 0; i < 6; i++) begin
      c = 8'($urandom());
      c[5] = 1'b0;      // keep random runs short
      runConfig(c);
    end
    // R1: reset clears a locked register
    doReset();
    check(regRdata == 8'h00 && !dividerValid, "R1 reset after lock", regRdata, 0);
    check(ratioOf(8'h7F) == 512, "R7 maximum ratio", ratioOf(8'h7F), 512);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule